// File: doc/BRIEF.md
# PLL Recalibration Sequencer

This block repeats the calibration of a fractional PLL after power-up, for the case where the first calibration ran before all of the PLL's output dividers had left reset. A single `start` pulse runs a fixed sequence over a memory-mapped master port that connects to the PLL's reconfiguration registers:

1. Select internal feedback.
2. Arm and fire a recalibration request.
3. Poll a status word until the calibration-busy flag drops.
4. Return the PLL to compensated feedback.
5. Wait for lock.

Every change to a single bit is done as a read-modify-write, so all other bits of the target word are kept. Both waiting loops give up after a programmable number of cycles. When a loop gives up, the block raises `error` and returns to idle.

Lock counts as observed when a completed status read shows the lock bit set, or when the `lock_in` pin is high at that completion. A one-cycle `done` pulse marks a successful run. `busy` is high from the cycle after `start` is accepted until the sequencer is back in idle.

Top module: `pll_recal_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `error`, `read` and `write` are all low.
- R2: The first bus operations read address 0x126 and write back the same word with bit 0 set, leaving every other bit unchanged.
- R3: The next operations read address 0x100 and write it back with bit 1 set, other bits unchanged. Then the value 0x00000001 is written to address 0x000. That write only ever happens while the last value written to 0x126 has bit 0 set.
- R4: After the request, address 0x280 is read repeatedly until a read returns bit 1 equal to 0. The loop makes exactly one more read than the number of reads that return bit 1 set.
- R5: After the calibration flag clears, address 0x126 is read and written back with bit 0 cleared, other bits unchanged.
- R6: The sequencer then reads 0x280 until a completed read shows bit 0 set or finds `lock_in` high. `done` is then high for exactly one cycle, after which `busy` is low and `error` is low.
- R7: While `waitrequest` is high, an issued read or write keeps its request, address and write data unchanged. `readdata` is taken only in the cycle the read completes.
- R8: If either polling loop is still not satisfied at a read completion once `timeout_cycles` cycles have passed in that loop, `error` goes high and `busy` goes low, with no further writes. `error` is never high while `busy` is high, and it clears when a new run is accepted.
- R9: A `start` pulse while `busy` is high has no effect: the run still issues exactly one request write to 0x000 and one `done` pulse.
- R10: `read` and `write` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a run when idle |
| lock_in | input | 1 | PLL lock pin, sampled at status read completion |
| timeout_cycles | input | TMR_W | Cycle limit for each polling loop |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on lock |
| error | output | 1 | Last run timed out |
| address | output | ADDR_W | Master port address |
| read | output | 1 | Read request |
| write | output | 1 | Write request |
| writedata | output | DATA_W | Write data |
| readdata | input | DATA_W | Read data |
| waitrequest | input | 1 | Slave stall; the request is held while high |

## Verification
The bound checker checks the following on every cycle:
- requests are held steady under `waitrequest`;
- reads and writes never overlap;
- a request write to 0x000 happens only after internal feedback was written;
- `error` and `busy` are never high together;
- `done` is followed by idle;
- the port is quiet after reset.

Only the bench scenarios can show the rest. These include the exact words written back, which show that the other bits were kept and that data was taken at completion despite stall-time garbage on `readdata`. They also include the number of status polls, and timeouts in each loop. Lock through the pin and start pulses ignored in mid-run are also covered only by the scenarios.

// File: rtl/pll_recal_seq.sv
module pll_recal_seq #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lock_in,
  input  logic [TMR_W-1:0]  timeout_cycles,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] address,
  output logic              read,
  output logic              write,
  output logic [DATA_W-1:0] writedata,
  input  logic [DATA_W-1:0] readdata,
  input  logic              waitrequest
);

  localparam logic [ADDR_W-1:0] A_FB   = ADDR_W'('h126);
  localparam logic [ADDR_W-1:0] A_ARM  = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_GO   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h280);
  localparam int FB_BIT   = 0;
  localparam int ARM_BIT  = 1;
  localparam int CAL_BIT  = 1;
  localparam int LOCK_BIT = 0;
  localparam logic [DATA_W-1:0] GO_WORD  = DATA_W'(1);
  localparam logic [DATA_W-1:0] FB_MASK  = DATA_W'(1) << FB_BIT;
  localparam logic [DATA_W-1:0] ARM_MASK = DATA_W'(1) << ARM_BIT;

  typedef enum logic [2:0] {
    S_IDLE, S_SET_FB, S_CAL_ARM, S_CAL_GO, S_CAL_WAIT, S_CLR_FB, S_LOCK_WAIT, S_DONE
  } st_t;

  st_t               state;
  logic [TMR_W-1:0]  tmr;
  logic [DATA_W-1:0] mod_word;
  logic              rd_ok, wr_ok, tmr_hit, locked;

  assign rd_ok   = read & ~waitrequest;
  assign wr_ok   = write & ~waitrequest;
  assign tmr_hit = tmr >= timeout_cycles;
  assign locked  = readdata[LOCK_BIT] | lock_in;
  assign busy    = state != S_IDLE;
  assign done    = state == S_DONE;

  always_comb begin
    case (state)
      S_SET_FB:  mod_word = readdata | FB_MASK;
      S_CAL_ARM: mod_word = readdata | ARM_MASK;
      S_CLR_FB:  mod_word = readdata & ~FB_MASK;
      default:   mod_word = readdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      read      <= 1'b0;
      write     <= 1'b0;
      address   <= '0;
      writedata <= '0;
      error     <= 1'b0;
      tmr       <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          error   <= 1'b0;
          read    <= 1'b1;
          address <= A_FB;
          state   <= S_SET_FB;
        end
        S_SET_FB: begin
          if (rd_ok) begin
            read      <= 1'b0;
            write     <= 1'b1;
            writedata <= mod_word;
          end else if (wr_ok) begin
            write   <= 1'b0;
            read    <= 1'b1;
            address <= A_ARM;
            state   <= S_CAL_ARM;
          end
        end
        S_CAL_ARM: begin
          if (rd_ok) begin
            read      <= 1'b0;
            write     <= 1'b1;
            writedata <= mod_word;
          end else if (wr_ok) begin
            address   <= A_GO;
            writedata <= GO_WORD;
            state     <= S_CAL_GO;
          end
        end
        S_CAL_GO: if (wr_ok) begin
          write   <= 1'b0;
          read    <= 1'b1;
          address <= A_STAT;
          tmr     <= '0;
          state   <= S_CAL_WAIT;
        end
        S_CAL_WAIT: begin
          if (tmr != '1) tmr <= tmr + 1'b1;
          if (rd_ok) begin
            if (!readdata[CAL_BIT]) begin
              address <= A_FB;
              state   <= S_CLR_FB;
            end else if (tmr_hit) begin
              read  <= 1'b0;
              error <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_CLR_FB: begin
          if (rd_ok) begin
            read      <= 1'b0;
            write     <= 1'b1;
            writedata <= mod_word;
          end else if (wr_ok) begin
            write   <= 1'b0;
            read    <= 1'b1;
            address <= A_STAT;
            tmr     <= '0;
            state   <= S_LOCK_WAIT;
          end
        end
        S_LOCK_WAIT: begin
          if (tmr != '1) tmr <= tmr + 1'b1;
          if (rd_ok) begin
            if (locked) begin
              read  <= 1'b0;
              state <= S_DONE;
            end else if (tmr_hit) begin
              read  <= 1'b0;
              error <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_recal_seq_chk.sv
module pll_recal_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [ADDR_W-1:0] address,
  input logic              read,
  input logic              write,
  input logic [DATA_W-1:0] writedata,
  input logic              waitrequest
);

  logic rst_q = 1'b0;
  logic fb_set;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) fb_set <= 1'b0;
    else if (write && !waitrequest && address == ADDR_W'('h126)) fb_set <= writedata[0];
  end

  always @(negedge clk)
    if (rst_q)
      a_r1_reset_idle: assert (!busy && !done && !error && !read && !write);

  a_r7_read_held: assert property (@(posedge clk) disable iff (rst)
    read && waitrequest |=> read && $stable(address));

  a_r7_write_held: assert property (@(posedge clk) disable iff (rst)
    write && waitrequest |=> write && $stable(address) && $stable(writedata));

  a_r3_req_under_intfb: assert property (@(posedge clk) disable iff (rst)
    write && address == '0 |-> fb_set);

  a_r6_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy && !done);

  a_r8_error_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(error && busy));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(read && write));

endmodule

bind pll_recal_seq pll_recal_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/pll_recal_seq_bench.sv
module pll_recal_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic lock_in = 1'b0;
  logic [15:0] tmo = 16'd500;
  logic busy, done, error, read, write, waitrequest;
  logic [9:0] address;
  logic [31:0] writedata, readdata;

  always #5 clk = ~clk;

  pll_recal_seq u_pll_recal_seq (
    .clk(clk), .rst(rst), .start(start), .lock_in(lock_in), .timeout_cycles(tmo),
    .busy(busy), .done(done), .error(error), .address(address), .read(read),
    .write(write), .writedata(writedata), .readdata(readdata), .waitrequest(waitrequest));

  int checks = 0, errors = 0;
  int cyc = 0, stall = 0;
  logic [31:0] r126, r100, r000;
  int cal_left = 0, cal_len = 0, lock_cnt = 0, lock_len = 0;
  int cal_polls = 0, go_writes = 0, bad_kick = 0, nlog = 0;
  int done_cnt = 0, hold_bad = 0, overlap = 0;
  logic [9:0] log_a [16];
  logic [31:0] log_d [16];
  logic pend_rd = 0, pend_wr = 0;
  logic [9:0] pend_a;
  logic [31:0] pend_d;

  function automatic logic [31:0] regval(input logic [9:0] a);
    case (a)
      10'h126: return r126;
      10'h100: return r100;
      10'h000: return r000;
      10'h280: return {30'd0, cal_left != 0, lock_cnt >= lock_len};
      default: return 32'd0;
    endcase
  endfunction

  assign waitrequest = (stall != 0) && (cyc % 3 != 2);
  assign readdata = waitrequest ? 32'hDEAD_BEEF : regval(address);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (read && write) overlap <= overlap + 1;
    if (pend_rd && (!read || address != pend_a)) hold_bad <= hold_bad + 1;
    if (pend_wr && (!write || address != pend_a || writedata != pend_d)) hold_bad <= hold_bad + 1;
    pend_rd <= read && waitrequest;
    pend_wr <= write && waitrequest;
    pend_a  <= address;
    pend_d  <= writedata;
    if (write && !waitrequest) begin
      if (nlog < 16) begin log_a[nlog] <= address; log_d[nlog] <= writedata; end
      nlog <= nlog + 1;
      case (address)
        10'h126: begin r126 <= writedata; if (!writedata[0]) lock_cnt <= 0; end
        10'h100: r100 <= writedata;
        10'h000: begin
          r000 <= writedata;
          go_writes <= go_writes + 1;
          if (writedata == 32'd1 && r126[0]) cal_left <= cal_len; else bad_kick <= bad_kick + 1;
        end
        default: ;
      endcase
    end
    if (read && !waitrequest && address == 10'h280) begin
      if (r126[0]) cal_polls <= cal_polls + 1;
      if (cal_left != 0) cal_left <= cal_left - 1;
      if (!r126[0]) lock_cnt <= lock_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic prep(input int cal, input int lk, input int stl, input logic pin, input int t);
    @(negedge clk);
    r126 = 32'hCAFE_0002; r100 = 32'h0000_5A50; r000 = 32'h0;
    cal_len = cal; lock_len = lk; stall = stl; lock_in = pin; tmo = 16'(t);
    cal_left = 0; lock_cnt = 0; cal_polls = 0; go_writes = 0; bad_kick = 0;
    nlog = 0; done_cnt = 0; hold_bad = 0; overlap = 0;
  endtask

  task automatic kick_and_wait();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_full_run(input int cal, input string tag);
    chk(nlog == 4, {tag, " R2 write count"}, nlog, 4);
    chk(log_a[0] == 10'h126 && log_d[0] == 32'hCAFE_0003, {tag, " R2 set intfb"}, log_d[0], 32'hCAFE_0003);
    chk(log_a[1] == 10'h100 && log_d[1] == 32'h0000_5A52, {tag, " R3 arm bit"}, log_d[1], 32'h0000_5A52);
    chk(log_a[2] == 10'h000 && log_d[2] == 32'h1 && bad_kick == 0, {tag, " R3 go write"}, log_d[2], 1);
    chk(cal_polls == cal + 1, {tag, " R4 poll count"}, cal_polls, cal + 1);
    chk(log_a[3] == 10'h126 && log_d[3] == 32'hCAFE_0002, {tag, " R5 clear intfb"}, log_d[3], 32'hCAFE_0002);
    chk(done_cnt == 1 && !busy && !error, {tag, " R6 done pulse"}, done_cnt, 1);
    chk(overlap == 0, {tag, " R10 no overlap"}, overlap, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !read && !write, "R1 reset state",
        {27'd0, busy, done, error, read, write}, 0);
    rst = 1'b0;
  endtask

  task automatic t_plain();
    prep(5, 3, 0, 1'b0, 500);
    kick_and_wait();
    check_full_run(5, "plain");
  endtask

  task automatic t_stalled();
    prep(7, 2, 1, 1'b0, 500);
    kick_and_wait();
    check_full_run(7, "stall");
    chk(hold_bad == 0, "R7 request held under waitrequest", hold_bad, 0);
  endtask

  task automatic t_pin_lock();
    prep(2, 100000, 0, 1'b1, 500);
    kick_and_wait();
    chk(done_cnt == 1 && !error, "R6 lock via pin", done_cnt, 1);
  endtask

  task automatic t_cal_timeout();
    prep(1000, 1, 0, 1'b0, 20);
    kick_and_wait();
    chk(error && !busy, "R8 cal timeout error", {30'd0, error, busy}, 2);
    chk(nlog == 3 && done_cnt == 0, "R8 no further writes", nlog, 3);
    prep(3, 1, 0, 1'b0, 500);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!error && busy, "R8 error cleared on start", {30'd0, error, busy}, 1);
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    check_full_run(3, "after_to");
  endtask

  task automatic t_lock_timeout();
    prep(2, 100000, 0, 1'b0, 15);
    kick_and_wait();
    chk(error && !busy && done_cnt == 0, "R8 lock timeout error", {30'd0, error, busy}, 2);
    chk(nlog == 4, "R8 lock timeout writes", nlog, 4);
  endtask

  task automatic t_busy_start();
    prep(30, 2, 0, 1'b0, 500);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(go_writes == 1, "R9 single request write", go_writes, 1);
    chk(done_cnt == 1 && nlog == 4, "R9 single run", done_cnt, 1);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    report();
  end

  initial begin
    r126 = 32'hCAFE_0002; r100 = 32'h0; r000 = 32'h0;
    t_reset();
    t_plain();
    t_stalled();
    t_pin_lock();
    t_cal_timeout();
    t_lock_timeout();
    t_busy_start();
    report();
  end
endmodule